// File: doc/BRIEF.md
# Block-Cipher Job Control Front End

This block sits between software and a bulk block-cipher datapath. Software uses a small register window to program a source address, a destination address, a byte count, a 128-bit key and a 128-bit chaining vector. It then writes a control word whose low bit launches the job. The block walks the source buffer one 16-byte block at a time. For each block it fetches the data from memory, passes it through an external cipher port with a valid/ready handshake, applies cipher-block chaining (CBC) when that mode is selected, and stores the result at the matching destination offset.

Only one block is in flight at any time. The launch bit stays high for the whole job and drops when the last block has been written, so software can poll it. Completion and length errors are recorded in sticky flags, which software clears by writing 1 to them. Each flag has its own disable bit for the interrupt line. In CBC mode the chaining register advances with every block, so a following job can continue the chain where the last one ended.

Register offsets (byte addresses on `reg_addr`):
- 0x00: control.
- 0x08: interrupt control and status.
- 0x10: source address.
- 0x14: destination address.
- 0x18: length.
- 0x30 to 0x3C: key words 0 to 3.
- 0x40 to 0x4C: chaining vector words 0 to 3.

Word n of the key or the vector holds bits [32n+31:32n].

Top module: `blkc_job_ctrl`

## Requirements
- R1: After reset, the control, interrupt, address, length and chaining-vector registers read 0, `irq` is low, and no memory or cipher request is active.
- R2: Writing control with bit 0 = 1 while idle and with a valid length starts a job. Bit 0 reads 1 while the job runs and 0 once the last block has been written, at which point the done flag (interrupt register bit 8) becomes set. Control bits 1 to 5 read back as written: bit 1 is 1 for encrypt and 0 for decrypt, bit 2 selects the programmed key, bits 3 and 4 are stored coherence hints, and bit 5 is 1 for CBC and 0 for ECB.
- R3: A start request with a length of zero, or a length that is not a multiple of 16, issues no memory request. Bit 0 reads 0 straight away, the error flag (interrupt register bit 9) is set, and the done flag is left unchanged.
- R4: In ECB mode, block i is read from source+16i and sent to the cipher unchanged. The cipher result is written to destination+16i. Blocks are handled in ascending order and each request is held until it is acknowledged.
- R5: In CBC encryption, the cipher input is the plaintext XOR the previous ciphertext block, and the chaining vector is used for the first block.
- R6: In CBC decryption, the written block is the cipher output XOR the previous input ciphertext block, and the chaining vector is used for the first block.
- R7: At the end of a CBC job, the chaining vector registers hold the last ciphertext block. An ECB job leaves them unchanged.
- R8: With control bit 2 = 1 the cipher uses the programmed key. With bit 2 = 0 it uses the parameter HW_KEY, whose default is 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0.
- R9: Writing 1 to interrupt register bit 8 or bit 9 clears that flag, and writing 0 leaves it set. The same write stores bits 1:0 as the disable bits for done and error.
- R10: `irq` is high exactly when a flag is set and its disable bit is 0.
- R11: While a job runs, writes to the control, source, destination, length, key and chaining-vector registers have no effect.
- R12: Key registers read as 0. Source and destination addresses read back with bits 3:0 forced to 0.
- R13: At most one of the memory read request, the cipher request and the memory write request is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Completion/error interrupt |
| mem_rd_req | output | 1 | Block read request, held until acknowledged |
| mem_rd_addr | output | AW | Block read address |
| mem_rd_ack | input | 1 | Read acknowledge, carries mem_rd_data |
| mem_rd_data | input | 128 | Read block |
| mem_wr_req | output | 1 | Block write request, held until acknowledged |
| mem_wr_addr | output | AW | Block write address |
| mem_wr_data | output | 128 | Block write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| ciph_req_valid | output | 1 | Cipher request valid |
| ciph_req_ready | input | 1 | Cipher accepts the request |
| ciph_req_data | output | 128 | Cipher input block |
| ciph_req_key | output | 128 | Key for this block |
| ciph_req_enc | output | 1 | 1 = encrypt, 0 = decrypt |
| ciph_rsp_valid | input | 1 | Cipher result valid (one cycle) |
| ciph_rsp_data | input | 128 | Cipher result |

## Verification
Jobs run in all four combinations of direction and chaining mode, with both key sources, lengths from one block up to a full sixteen, random buffer contents and a cipher port whose ready signal stalls at random. Comparing the destination buffer against independently computed ECB and CBC results separates a wrong XOR partner or a wrong block order from correct chaining. The chaining-vector readback separates the ECB and CBC end states. Writes issued in the middle of long jobs, and zero or odd lengths, exercise the guard paths. The sticky flags are then set, masked and cleared in turn to tell the flag state apart from the `irq` gating.

// File: rtl/blkc_job_ctrl.sv
module blkc_job_ctrl #(
  parameter int AW = 32,
  parameter int LW = 20,
  parameter logic [127:0] HW_KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [127:0]  mem_rd_data,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [127:0]  mem_wr_data,
  input  logic          mem_wr_ack,
  output logic          ciph_req_valid,
  input  logic          ciph_req_ready,
  output logic [127:0]  ciph_req_data,
  output logic [127:0]  ciph_req_key,
  output logic          ciph_req_enc,
  input  logic          ciph_rsp_valid,
  input  logic [127:0]  ciph_rsp_data
);
  localparam int BW = 128;
  localparam int BB = BW / 8;
  localparam int OW = $clog2(BB);
  localparam logic [AW-1:0] AMASK = ~AW'(BB - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CI, S_CW, S_WR} st_t;

  st_t            st;
  logic [5:0]     ctl;
  logic [1:0]     dis;
  logic           done_f, err_f;
  logic [AW-1:0]  src_r, dst_r, cur_src, cur_dst;
  logic [LW-1:0]  len_r, rem;
  logic [BW-1:0]  key_r, iv_r, blk;

  wire busy = ctl[0];
  wire enc  = ctl[1];
  wire cbc  = ctl[5];
  wire wr_ok = reg_wr && !busy;
  wire [1:0] widx = reg_addr[3:2];
  wire hit_ctl = reg_addr == 8'h00;
  wire hit_int = reg_addr == 8'h08;
  wire hit_key = reg_addr[7:4] == 4'h3 && reg_addr[1:0] == 2'b00;
  wire hit_iv  = reg_addr[7:4] == 4'h4 && reg_addr[1:0] == 2'b00;
  wire len_bad = len_r == '0 || len_r[OW-1:0] != '0;
  wire last    = rem == LW'(BB);

  wire [BW-1:0] blk_out = (!enc && cbc) ? (ciph_rsp_data ^ iv_r) : ciph_rsp_data;

  assign mem_rd_req     = st == S_RD;
  assign mem_rd_addr    = cur_src;
  assign ciph_req_valid = st == S_CI;
  assign ciph_req_data  = (enc && cbc) ? (blk ^ iv_r) : blk;
  assign ciph_req_key   = ctl[2] ? key_r : HW_KEY;
  assign ciph_req_enc   = enc;
  assign mem_wr_req     = st == S_WR;
  assign mem_wr_addr    = cur_dst;
  assign mem_wr_data    = blk;
  assign irq            = |({err_f, done_f} & ~dis);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctl     <= '0;
      dis     <= '0;
      done_f  <= 1'b0;
      err_f   <= 1'b0;
      src_r   <= '0;
      dst_r   <= '0;
      len_r   <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      rem     <= '0;
      key_r   <= '0;
      iv_r    <= '0;
      blk     <= '0;
    end else begin
      if (reg_wr && hit_int) begin
        dis <= reg_wdata[1:0];
        if (reg_wdata[8]) done_f <= 1'b0;
        if (reg_wdata[9]) err_f  <= 1'b0;
      end
      if (wr_ok) begin
        if (reg_addr == 8'h10) src_r <= AW'(reg_wdata) & AMASK;
        if (reg_addr == 8'h14) dst_r <= AW'(reg_wdata) & AMASK;
        if (reg_addr == 8'h18) len_r <= reg_wdata[LW-1:0];
        if (hit_key) key_r[32*widx +: 32] <= reg_wdata;
        if (hit_iv)  iv_r[32*widx +: 32]  <= reg_wdata;
        if (hit_ctl) begin
          ctl[5:1] <= reg_wdata[5:1];
          if (reg_wdata[0]) begin
            if (len_bad) begin
              err_f <= 1'b1;
            end else begin
              ctl[0]  <= 1'b1;
              cur_src <= src_r;
              cur_dst <= dst_r;
              rem     <= len_r;
              st      <= S_RD;
            end
          end
        end
      end
      case (st)
        S_RD: if (mem_rd_ack) begin
          blk <= mem_rd_data;
          st  <= S_CI;
        end
        S_CI: if (ciph_req_ready) st <= S_CW;
        S_CW: if (ciph_rsp_valid) begin
          blk <= blk_out;
          if (cbc) iv_r <= enc ? ciph_rsp_data : blk;
          st <= S_WR;
        end
        S_WR: if (mem_wr_ack) begin
          cur_src <= cur_src + AW'(BB);
          cur_dst <= cur_dst + AW'(BB);
          rem     <= rem - LW'(BB);
          if (last) begin
            ctl[0] <= 1'b0;
            done_f <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00: reg_rdata[5:0] = ctl;
      8'h08: begin
        reg_rdata[1:0] = dis;
        reg_rdata[8]   = done_f;
        reg_rdata[9]   = err_f;
      end
      8'h10: reg_rdata = 32'(src_r);
      8'h14: reg_rdata = 32'(dst_r);
      8'h18: reg_rdata = 32'(len_r);
      8'h40, 8'h44, 8'h48, 8'h4C: reg_rdata = iv_r[32*widx +: 32];
      default: ;
    endcase
  end
endmodule

// File: rtl/blkc_job_ctrl_chk.sv
module blkc_job_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done_f,
  input logic [1:0]    dis,
  input logic          irq,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_rd_req,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_ack,
  input logic          mem_wr_req,
  input logic          mem_wr_ack,
  input logic          ciph_req_valid,
  input logic          ciph_req_ready,
  input logic [127:0]  ciph_req_data
);
  wire clr_done = reg_wr && reg_addr == 8'h08 && reg_wdata[8];

  // R13
  a_r13_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, ciph_req_valid, mem_wr_req}));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd_req || ciph_req_valid || mem_wr_req));

  a_r2_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_f);

  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  a_r4_ci_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ciph_req_valid && !ciph_req_ready |=> ciph_req_valid && $stable(ciph_req_data));

  a_r4_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_f && !clr_done |=> done_f);

  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    dis == 2'b11 |-> !irq);
endmodule

bind blkc_job_ctrl blkc_job_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(ctl[0]), .done_f(done_f), .dis(dis), .irq(irq),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
  .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
  .ciph_req_valid(ciph_req_valid), .ciph_req_ready(ciph_req_ready),
  .ciph_req_data(ciph_req_data)
);

// File: tb/blkc_job_ctrl_tb.sv
module blkc_job_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int LAT = 3;
  localparam logic [127:0] HWK = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  logic mem_rd_req, mem_rd_ack, mem_wr_req, mem_wr_ack;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic [127:0] mem_rd_data, mem_wr_data;
  logic ciph_req_valid, ciph_req_ready, ciph_req_enc, ciph_rsp_valid;
  logic [127:0] ciph_req_data, ciph_req_key, ciph_rsp_data;

  int nchk = 0, nerr = 0, job = 0, rd_cnt = 0;
  logic [127:0] src_mem [0:63];
  logic [127:0] dst_mem [0:63];
  int dst_job [0:63];
  int lat_cnt;

  always #(CLK_P/2) clk = ~clk;

  blkc_job_ctrl u_dut (.*);

  function automatic logic [127:0] bc_enc(input logic [127:0] x, input logic [127:0] k);
    return {x[119:0], x[127:120]} ^ k;
  endfunction
  function automatic logic [127:0] bc_dec(input logic [127:0] y, input logic [127:0] k);
    logic [127:0] t = y ^ k;
    return {t[7:0], t[127:8]};
  endfunction
  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_ack <= 0; mem_wr_ack <= 0; mem_rd_data <= '0;
      ciph_req_ready <= 0; ciph_rsp_valid <= 0; ciph_rsp_data <= '0; lat_cnt <= 0;
    end else begin
      if (mem_rd_req && !mem_rd_ack) begin
        mem_rd_ack <= 1; mem_rd_data <= src_mem[mem_rd_addr[9:4]]; rd_cnt <= rd_cnt + 1;
      end else mem_rd_ack <= 0;
      if (mem_wr_req && !mem_wr_ack) begin
        mem_wr_ack <= 1; dst_mem[mem_wr_addr[9:4]] <= mem_wr_data; dst_job[mem_wr_addr[9:4]] <= job;
      end else mem_wr_ack <= 0;
      ciph_req_ready <= ($urandom % 4) != 0;
      ciph_rsp_valid <= 0;
      if (ciph_req_valid && ciph_req_ready) begin
        lat_cnt <= LAT;
        ciph_rsp_data <= ciph_req_enc ? bc_enc(ciph_req_data, ciph_req_key)
                                      : bc_dec(ciph_req_data, ciph_req_key);
      end else if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) ciph_rsp_valid <= 1;
      end
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_iv(output logic [127:0] v);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(8'h40 + 8'(4*i), w); v[32*i +: 32] = w;
    end
  endtask

  task automatic wait_done();
    logic [31:0] r;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h00, r);
      if (r[0] == 0) break;
    end
  endtask

  task automatic run_job(input bit e, input bit c, input bit w, input int nb);
    logic [127:0] k, iv0, prev, x, ex, ivr, ke;
    logic [31:0] r, cw;
    int sb, db;
    job++;
    sb = $urandom_range(0, 16 - nb);
    db = 32 + $urandom_range(0, 32 - nb);
    for (int i = 0; i < nb; i++) src_mem[sb + i] = rnd128();
    k = rnd128(); iv0 = rnd128();
    ke = w ? k : HWK;
    wr(8'h10, 32'(sb * 16));
    wr(8'h14, 32'(db * 16));
    wr(8'h18, 32'(nb * 16));
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(4*i), k[32*i +: 32]);
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(4*i), iv0[32*i +: 32]);
    cw = {26'd0, c, 2'($urandom), w, e, 1'b1};
    wr(8'h00, cw);
    rd(8'h00, r);
    check("R2 start reads busy", r, cw);
    if (nb >= 3) begin
      wr(8'h10, 32'h3f0);
      wr(8'h40, ~iv0[31:0]);
      wr(8'h34, ~k[63:32]);
      wr(8'h18, 32'h0fff0);
      wr(8'h00, 32'h0);
    end
    wait_done();
    rd(8'h00, r);
    check("R2 start clears at end", r, {cw[31:1], 1'b0});
    prev = iv0;
    for (int i = 0; i < nb; i++) begin
      x = src_mem[sb + i];
      if (e) begin
        ex = bc_enc(c ? (x ^ prev) : x, ke);
        prev = ex;
      end else begin
        ex = bc_dec(x, ke) ^ (c ? prev : 128'd0);
        prev = x;
      end
      check(e ? (c ? "R5 cbc enc block" : "R4 ecb enc block")
              : (c ? "R6 cbc dec block" : "R4 ecb dec block"), dst_mem[db + i], ex);
      check(w ? "R4 block written this job" : "R8 hw key block written", 128'(dst_job[db + i]), 128'(job));
    end
    rd_iv(ivr);
    check("R7 chaining vector at end", ivr, c ? prev : iv0);
    if (nb >= 3) begin
      rd(8'h10, r); check("R11 src ignored while busy", r, 32'(sb * 16));
      rd(8'h18, r); check("R11 len ignored while busy", r, 32'(nb * 16));
    end
    rd(8'h08, r);
    check("R2 done flag set", r[9:8], 2'b01);
    check("R10 irq on done", irq, 1'b1);
    wr(8'h08, 32'h100);
    rd(8'h08, r);
    check("R9 done cleared", r[8], 1'b0);
    check("R10 irq low after clear", irq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [127:0] v;
    int c0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      src_mem[i] = '0; dst_mem[i] = '0; dst_job[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, r); check("R1 control reset", r, 0);
    rd(8'h08, r); check("R1 interrupt reset", r, 0);
    rd(8'h18, r); check("R1 length reset", r, 0);
    rd_iv(v);     check("R1 vector reset", v, 0);
    check("R1 irq reset", irq, 0);

    c0 = rd_cnt;
    wr(8'h00, 32'h1);
    rd(8'h00, r); check("R3 zero length no start", r[0], 0);
    rd(8'h08, r); check("R3 error flag set", r[9:8], 2'b10);
    repeat (5) @(negedge clk);
    check("R3 no read issued", rd_cnt, c0);
    check("R10 irq on error", irq, 1);
    wr(8'h08, 32'h2);
    check("R10 irq masked", irq, 0);
    rd(8'h08, r); check("R9 write 0 keeps error", r, 32'h202);
    wr(8'h08, 32'h200);
    rd(8'h08, r); check("R9 error cleared", r, 0);
    wr(8'h18, 32'd24);
    wr(8'h00, 32'h23);
    rd(8'h00, r); check("R3 odd length no start", r, 32'h22);
    rd(8'h08, r); check("R3 odd length error", r[9], 1);
    check("R3 no read issued odd", rd_cnt, c0);
    wr(8'h08, 32'h200);

    wr(8'h30, 32'hcafef00d);
    rd(8'h30, r); check("R12 key reads zero", r, 0);
    wr(8'h14, 32'h1237);
    rd(8'h14, r); check("R12 dst low bits zero", r, 32'h1230);

    run_job(1, 0, 1, 4);
    run_job(1, 1, 1, 5);
    run_job(0, 1, 1, 3);
    run_job(0, 0, 0, 3);
    run_job(1, 1, 0, 1);
    run_job(0, 1, 1, 16);
    for (int j = 0; j < 10; j++)
      run_job(1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(1, 8));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule